// File: doc/BRIEF.md
# Ready-Time Ordered Response Queue

This block parks finished read responses until the moment their data is due and then hands them back one per cycle, earliest due time first. Each entry is a tag plus a ready timestamp. The block owns a free-running time counter and releases the head entry once the counter has reached the head's timestamp.

New entries are placed in sorted position when they arrive, so the head is always the earliest due entry. An entry whose time equals one already held goes behind it. Every release frees one slot of read capacity. If a requester was turned away earlier, the release also produces a retry pulse so that it can try again.

Entries are stored in a small sorted shift array. A release and an insert can happen in the same cycle. The block flags inserts that find no room and reports when it holds nothing, for drain completion.

Top module: `ready_order_queue`

## Requirements
- R1: After reset `cur_time` is 0, `occupancy` is 0, `all_empty` is 1, and `resp_valid`, `slot_freed`, `retry` and `ins_err` are 0.
- R2: `cur_time` is an unsigned counter that increases by exactly one on every clock edge after reset. Timestamps are compared unsigned, with no wrap-around.
- R3: An accepted entry is placed before the first held entry whose ready time is strictly greater than its own, or at the tail if there is none. Responses therefore leave in non-decreasing ready-time order, and entries with equal times leave in arrival order.
- R4: When the queue is non-empty and the head's ready time is at most `cur_time` at a clock edge, the head is removed at that edge. One cycle later `resp_valid` is 1 and `resp_tag` carries the head's tag for exactly one cycle.
- R5: At most one response leaves per cycle. `occupancy` equals the number of held entries, and between consecutive cycles it changes by at most one.
- R6: `slot_freed` pulses in exactly the cycles in which `resp_valid` is 1.
- R7: A cycle with `rd_blocked` high records a pending retry. `retry` pulses together with the next `slot_freed`, and that pulse clears the pending state. This includes a release in the same cycle as the `rd_blocked` pulse.
- R8: An insert that finds the queue full, after any release in the same cycle, is dropped. `ins_err` is 1 in the following cycle, and `occupancy` does not change because of it.
- R9: A release and an insert in the same cycle both take effect. A full queue that releases its head accepts the new entry in that cycle.
- R10: `all_empty` is 1 exactly when `occupancy` is 0.
- R11: The user ensures that an inserted ready time is never below `cur_time`. An entry inserted with ready time equal to `cur_time` leaves at the next edge if it becomes the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request this cycle |
| ins_tag | input | TAG_W | Tag of the entry to insert |
| ins_time | input | TIME_W | Ready time of the entry to insert |
| rd_blocked | input | 1 | A read was refused elsewhere; request a retry at the next freed slot |
| resp_valid | output | 1 | A response is released this cycle |
| resp_tag | output | TAG_W | Tag of the released response |
| slot_freed | output | 1 | One read-capacity slot was freed |
| retry | output | 1 | Pending retry is signalled now |
| ins_err | output | 1 | The previous cycle's insert was dropped because the queue was full |
| all_empty | output | 1 | No entry is held |
| occupancy | output | $clog2(DEPTH+1) | Number of held entries |
| cur_time | output | TIME_W | Free-running time counter |

## Verification
A release of the head and a sorted insert can fall on the same clock edge, and so can a release and a `rd_blocked` pulse. The bench fills the queue with entries that share one ready time. It then offers inserts on every cycle around that time, so that the first offers are dropped as overflow and the offer on the due cycle is accepted into the slot that the release frees. `rd_blocked` pulses are placed both in the release cycle and between releases. A behavioural queue model in the bench is compared with every output on every cycle. Order, occupancy, error and retry outcomes are each judged against the model.

// File: rtl/ready_order_queue.sv
module ready_order_queue #(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = 4,
  parameter int TIME_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ins_valid,
  input  logic [TAG_W-1:0]           ins_tag,
  input  logic [TIME_W-1:0]          ins_time,
  input  logic                       rd_blocked,
  output logic                       resp_valid,
  output logic [TAG_W-1:0]           resp_tag,
  output logic                       slot_freed,
  output logic                       retry,
  output logic                       ins_err,
  output logic                       all_empty,
  output logic [$clog2(DEPTH+1)-1:0] occupancy,
  output logic [TIME_W-1:0]          cur_time
);
  localparam int CW = $clog2(DEPTH+1);

  logic [TIME_W-1:0] t_q [DEPTH];
  logic [TAG_W-1:0]  g_q [DEPTH];
  logic [TIME_W-1:0] t_s [DEPTH];
  logic [TAG_W-1:0]  g_s [DEPTH];
  logic [TIME_W-1:0] t_d [DEPTH];
  logic [TAG_W-1:0]  g_d [DEPTH];
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [TIME_W-1:0] now_q;
  logic              pend_q, pop, accept;

  assign pop = (cnt_q != '0) && (t_q[0] <= now_q);

  always_comb begin
    int n, pos;
    n = int'(cnt_q) - (pop ? 1 : 0);
    for (int i = 0; i < DEPTH; i++) begin
      if (pop && i < DEPTH-1) begin
        t_s[i] = t_q[i+1];
        g_s[i] = g_q[i+1];
      end else if (pop) begin
        t_s[i] = '0;
        g_s[i] = '0;
      end else begin
        t_s[i] = t_q[i];
        g_s[i] = g_q[i];
      end
    end
    accept = ins_valid && (n < DEPTH);
    pos = 0;
    for (int i = 0; i < DEPTH; i++)
      if (i < n && t_s[i] <= ins_time) pos = i + 1;
    for (int i = 0; i < DEPTH; i++) begin
      t_d[i] = t_s[i];
      g_d[i] = g_s[i];
      if (accept) begin
        if (i == pos) begin
          t_d[i] = ins_time;
          g_d[i] = ins_tag;
        end else if (i > pos && i > 0) begin
          t_d[i] = t_s[i-1];
          g_d[i] = g_s[i-1];
        end
      end
    end
    cnt_d = CW'(n + (accept ? 1 : 0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      now_q      <= '0;
      pend_q     <= 1'b0;
      resp_valid <= 1'b0;
      resp_tag   <= '0;
      slot_freed <= 1'b0;
      retry      <= 1'b0;
      ins_err    <= 1'b0;
      all_empty  <= 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
        t_q[i] <= '0;
        g_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        t_q[i] <= t_d[i];
        g_q[i] <= g_d[i];
      end
      cnt_q      <= cnt_d;
      now_q      <= now_q + 1'b1;
      resp_valid <= pop;
      resp_tag   <= g_q[0];
      slot_freed <= pop;
      retry      <= pop && (pend_q || rd_blocked);
      pend_q     <= (pend_q || rd_blocked) && !pop;
      ins_err    <= ins_valid && !accept;
      all_empty  <= (cnt_d == '0);
    end
  end

  assign occupancy = cnt_q;
  assign cur_time  = now_q;

  always @(posedge clk)
    if (rst_n)
      for (int i = 0; i < DEPTH-1; i++)
        if (i + 1 < int'(cnt_q))
          AST_SORTED: assert (t_q[i] <= t_q[i+1]); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1) || (cnt_q + 1'b1 == $past(cnt_q))); // R5
  AST_NO_EMIT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($past(cnt_q) != '0)); // R4
  AST_ERR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ins_err |-> ($past(cnt_q) == CW'(DEPTH))); // R8
  AST_RETRY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    retry |-> slot_freed); // R7
  AST_EMPTY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    all_empty == (cnt_q == '0)); // R10
endmodule

// File: tb/tb_ready_order_queue.sv
`timescale 1ns/1ps
module tb_ready_order_queue;
  localparam int DEPTH = 8, TAG_W = 4, TIME_W = 16, CW = $clog2(DEPTH+1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 1'b0, rd_blocked = 1'b0;
  logic [TAG_W-1:0] ins_tag = '0;
  logic [TIME_W-1:0] ins_time = '0;
  logic resp_valid, slot_freed, retry, ins_err, all_empty;
  logic [TAG_W-1:0] resp_tag;
  logic [CW-1:0] occupancy;
  logic [TIME_W-1:0] cur_time;

  ready_order_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .TIME_W(TIME_W)) dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_tag(ins_tag),
    .ins_time(ins_time), .rd_blocked(rd_blocked), .resp_valid(resp_valid),
    .resp_tag(resp_tag), .slot_freed(slot_freed), .retry(retry),
    .ins_err(ins_err), .all_empty(all_empty), .occupancy(occupancy),
    .cur_time(cur_time));

  always #2.5 clk = ~clk;

  int qt[$];
  int qg[$];
  int m_now = 0, tagc = 0;
  bit m_pend = 0, e_valid = 0, e_free = 0, e_retry = 0, e_err = 0, e_empty = 1;
  int e_tag = 0, e_cnt = 0;
  int checks = 0, fails = 0;
  bit done = 0, run = 0;

  always @(posedge clk) if (rst_n) begin
    bit p, acc;
    int k;
    p = (qt.size() > 0) && (qt[0] <= m_now);
    e_valid = p; e_free = p;
    if (p) begin
      e_tag = qg[0];
      void'(qt.pop_front());
      void'(qg.pop_front());
    end
    e_retry = p && (m_pend || rd_blocked);
    m_pend = (m_pend || rd_blocked) && !p;
    acc = ins_valid && (qt.size() < DEPTH);
    e_err = ins_valid && !acc;
    if (acc) begin
      k = qt.size();
      for (int i = qt.size() - 1; i >= 0; i--) if (qt[i] > int'(ins_time)) k = i;
      qt.insert(k, int'(ins_time));
      qg.insert(k, int'(ins_tag));
    end
    e_cnt = qt.size();
    e_empty = (qt.size() == 0);
    m_now++;
  end

  task automatic chk(input string r, input int act, input int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at time %0t", r, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (run) begin
    checks++;
    chk("R2 cur_time", int'(cur_time), m_now);
    chk("R4 resp_valid", int'(resp_valid), int'(e_valid));
    if (e_valid) chk("R3 R4 resp_tag order", int'(resp_tag), e_tag);
    chk("R6 slot_freed", int'(slot_freed), int'(e_free));
    chk("R7 retry", int'(retry), int'(e_retry));
    chk("R8 ins_err", int'(ins_err), int'(e_err));
    chk("R5 R9 occupancy", int'(occupancy), e_cnt);
    chk("R10 all_empty", int'(all_empty), int'(e_empty));
  end

  task automatic step(input bit v, input int dt, input bit rej);
    ins_valid = v;
    ins_time = TIME_W'(m_now + dt);
    ins_tag = TAG_W'(tagc);
    if (v) tagc++;
    rd_blocked = rej;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    chk("R1 reset cur_time", int'(cur_time), 0);
    chk("R1 reset occupancy", int'(occupancy), 0);
    chk("R1 reset all_empty", int'(all_empty), 1);
    chk("R1 reset outputs", int'({resp_valid, slot_freed, retry, ins_err}), 0);
    rst_n = 1'b1;
    run = 1'b1;
    // in-order with gaps
    for (int i = 0; i < 4; i++) step(1, 3 + 2 * i, 0);
    idle(12);
    // reverse order: each new entry becomes head (R3)
    for (int i = 0; i < 5; i++) step(1, 20 - 3 * i, 0);
    idle(25);
    // ties leave in arrival order
    for (int i = 0; i < 5; i++) step(1, 10 - i, 0);
    idle(15);
    // R11: ready now
    step(1, 0, 0); step(1, 0, 1); idle(4);
    // fill with equal times, overflow, then same-cycle pop and insert (R8 R9)
    for (int i = 0; i < DEPTH; i++) step(1, 30 - i, 0);
    for (int i = 0; i < 4; i++) step(1, 5, 0);
    while (m_now < 0) step(0, 0, 0);
    for (int i = 0; i < 30; i++) step(1, 40, (i % 7) == 0);
    idle(60);
    // rd_blocked between releases (R7)
    step(1, 6, 0); step(0, 0, 1); step(1, 9, 0); idle(12);
    step(0, 0, 1); idle(3); step(1, 2, 0); idle(6);
    // random mix
    for (int i = 0; i < 3000; i++)
      step(($urandom % 3) != 0, int'($urandom % 24), ($urandom % 9) == 0);
    idle(60);
    run = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule